// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This block turns one 512-bit message block into the stream of word pairs that the 64 compression rounds of the SM3 hash consume. For every round j it presents W[j] and W'[j] = W[j] xor W[j+4], together with the round index, and it holds them until the round engine asks for the next pair.

Sixteen words are unpacked from the block when a load is requested. After that a 16-word sliding window produces one new expanded word per advance, so the block never stores all 68 words. The window always covers W[j] through W[j+15], which places W[j+4] in it next to W[j]. The round engine controls the pace with the advance strobe and may hold a round for as many cycles as it needs.

Top module: `sm3_msg_expand`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `valid_o` is 0, `round_o` is 0, and `w_o` and `wp_o` are 0.
- R2: In the cycle after `load_i` is sampled high, `valid_o` is 1, `round_o` is 0 and `w_o` is W[0]. Word k of the block is `block_i[511-32k -: 32]`, so byte 0 (`block_i[511:504]`) is the most significant byte of W[0].
- R3: While `valid_o` is 1, `wp_o` equals W[round_o] xor W[round_o+4].
- R4: An advance (`next_i` high while `valid_o` is 1 and `load_i` is low) with `round_o` below 63 raises `round_o` by one in the next cycle and presents that round's W and W'.
- R5: While `valid_o` is 1 and both `next_i` and `load_i` are low, `round_o`, `w_o` and `wp_o` keep their values.
- R6: For j from 16 to 67, W[j] = P1(W[j-16] ^ W[j-9] ^ rol(W[j-3],15)) ^ rol(W[j-13],7) ^ W[j-6], where P1(x) = x ^ rol(x,15) ^ rol(x,23).
- R7: An advance at round 63 makes `valid_o` 0 and `round_o` 0 in the next cycle. While the unit is idle, `next_i` has no effect and `valid_o` and `round_o` stay 0.
- R8: A load while a block is in progress discards that block and restarts at round 0 with the new block's words.
- R9: When `load_i` and `next_i` are both high in the same cycle, the load takes precedence and the next cycle presents round 0 of the new block.
- R10: `block_i` is sampled only in a load cycle. Changes to it at any other time do not alter the words that are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `block_i` and restart at round 0 |
| block_i | input | 512 | Message block, byte 0 in bits 511:504 |
| next_i | input | 1 | Advance strobe from the round engine |
| valid_o | output | 1 | A round's word pair is presented |
| round_o | output | 6 | Index of the presented round |
| w_o | output | 32 | W[round] |
| wp_o | output | 32 | W[round] xor W[round+4] |

## Verification
A load and an advance can fall in the same cycle: a new block can arrive in the cycle where the round engine steps the old block, either in mid-block or at round 63. The bench provokes this by raising `load_i` and `next_i` together after a few advances. It judges the result by the next cycle, which must show round 0 and the first word pair of the new block, with no sign of the step on the old one. A reference model of the recurrence computes all 68 words of two test blocks, and the bench compares every presented pair against it, including rounds that are held for extra cycles.

// File: rtl/sm3_pkg.sv
package sm3_pkg;
  localparam int WORD_W     = 32;
  localparam int BLK_WORDS  = 16;
  localparam int BLK_W      = WORD_W * BLK_WORDS;
  localparam int NUM_ROUNDS = 64;
  localparam int LOOKAHEAD  = 4;
  localparam int ROUND_W    = $clog2(NUM_ROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rol(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t perm_p1(input word_t x);
    return x ^ rol(x, 15) ^ rol(x, 23);
  endfunction
endpackage

// File: rtl/sm3_block_unpack.sv
module sm3_block_unpack
  import sm3_pkg::*;
#(
  parameter int NW = BLK_WORDS
) (
  input  logic [NW*WORD_W-1:0] block_i,
  output word_t                words_o [NW]
);
  // word 0 sits at the top of the vector (big-endian byte order)
  for (genvar k = 0; k < NW; k++) begin : g_word
    assign words_o[k] = block_i[NW*WORD_W-1-k*WORD_W -: WORD_W];
  end
endmodule

// File: rtl/sm3_expand_word.sv
module sm3_expand_word
  import sm3_pkg::*;
(
  input  word_t tap16_i,
  input  word_t tap13_i,
  input  word_t tap9_i,
  input  word_t tap6_i,
  input  word_t tap3_i,
  output word_t new_o
);
  word_t mix;
  always_comb begin
    mix   = tap16_i ^ tap9_i ^ rol(tap3_i, 15);
    new_o = perm_p1(mix) ^ rol(tap13_i, 7) ^ tap6_i;
  end
endmodule

// File: rtl/sm3_round_ctrl.sv
module sm3_round_ctrl
  import sm3_pkg::*;
#(
  parameter int ROUNDS = NUM_ROUNDS,
  localparam int RW    = $clog2(ROUNDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          next_i,
  output logic          valid_o,
  output logic [RW-1:0] round_o,
  output logic          shift_o
);
  localparam logic [RW-1:0] LastRound = RW'(ROUNDS - 1);

  logic          valid_q;
  logic [RW-1:0] round_q;

  assign shift_o = valid_q & next_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      round_q <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      round_q <= '0;
    end else if (shift_o) begin
      if (round_q == LastRound) begin
        valid_q <= 1'b0;
        round_q <= '0;
      end else begin
        round_q <= round_q + 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign round_o = round_q;
endmodule

// File: rtl/sm3_msg_expand.sv
module sm3_msg_expand
  import sm3_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BLK_W-1:0]   block_i,
  input  logic               next_i,
  output logic               valid_o,
  output logic [ROUND_W-1:0] round_o,
  output logic [WORD_W-1:0]  w_o,
  output logic [WORD_W-1:0]  wp_o
);
  localparam int NW = BLK_WORDS;

  word_t blk_words [NW];
  word_t win_q     [NW];
  word_t new_word;
  logic  shift;

  sm3_block_unpack #(.NW(NW)) u_unpack (
    .block_i (block_i),
    .words_o (blk_words)
  );

  // window holds W[j..j+15]; next word W[j+16] uses offsets 0,3,7,10,13
  sm3_expand_word u_expand (
    .tap16_i (win_q[0]),
    .tap13_i (win_q[3]),
    .tap9_i  (win_q[7]),
    .tap6_i  (win_q[10]),
    .tap3_i  (win_q[13]),
    .new_o   (new_word)
  );

  sm3_round_ctrl #(.ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .next_i  (next_i),
    .valid_o (valid_o),
    .round_o (round_o),
    .shift_o (shift)
  );

  for (genvar i = 0; i < NW; i++) begin : g_win
    word_t nxt;
    if (i == NW - 1) begin : g_tail
      assign nxt = new_word;
    end else begin : g_body
      assign nxt = win_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     win_q[i] <= '0;
      else if (load_i) win_q[i] <= blk_words[i];
      else if (shift)  win_q[i] <= nxt;
    end
  end

  assign w_o  = win_q[0];
  assign wp_o = win_q[0] ^ win_q[LOOKAHEAD];
endmodule

// File: rtl/sm3_msg_expand_chk.sv
module sm3_msg_expand_chk
  import sm3_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               next_i,
  input logic               valid_o,
  input logic [ROUND_W-1:0] round_o,
  input logic [WORD_W-1:0]  w_o,
  input logic [WORD_W-1:0]  wp_o
);
  localparam logic [ROUND_W-1:0] LastRound = ROUND_W'(NUM_ROUNDS - 1);

  p_load_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o && round_o == '0);

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && next_i && !load_i && round_o != LastRound
      |=> valid_o && round_o == $past(round_o) + 1'b1);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !next_i && !load_i
      |=> valid_o && $stable(round_o) && $stable(w_o) && $stable(wp_o));

  p_finish_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && next_i && !load_i && round_o == LastRound |=> !valid_o);

  p_idle_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !load_i |=> !valid_o && round_o == '0);

  p_collide_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && next_i |=> round_o == '0);
endmodule

bind sm3_msg_expand sm3_msg_expand_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .next_i  (next_i),
  .valid_o (valid_o),
  .round_o (round_o),
  .w_o     (w_o),
  .wp_o    (wp_o)
);

// File: tb/tb_sm3_msg_expand.sv
module tb_sm3_msg_expand;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [511:0] block_i = '0;
  logic         next_i = 1'b0;
  logic         valid_o;
  logic [5:0]   round_o;
  logic [31:0]  w_o;
  logic [31:0]  wp_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_w [68];

  always #2 clk_i = ~clk_i;

  sm3_msg_expand dut (.*);

  function automatic logic [31:0] m_rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] m_p1(input logic [31:0] x);
    return x ^ m_rol(x, 15) ^ m_rol(x, 23);
  endfunction

  task automatic model(input logic [511:0] b);
    for (int k = 0; k < 16; k++) exp_w[k] = b[511-32*k -: 32];
    for (int j = 16; j < 68; j++)
      exp_w[j] = m_p1(exp_w[j-16] ^ exp_w[j-9] ^ m_rol(exp_w[j-3], 15))
                 ^ m_rol(exp_w[j-13], 7) ^ exp_w[j-6];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_load(input logic [511:0] b, input logic nxt);
    @(negedge clk_i);
    load_i = 1'b1; block_i = b; next_i = nxt;
    @(negedge clk_i);
    load_i = 1'b0; next_i = 1'b0;
  endtask

  task automatic step_next();
    next_i = 1'b1;
    @(negedge clk_i);
    next_i = 1'b0;
  endtask

  task automatic chk_round(input int j);
    chk("R4 round", 32'(round_o), 32'(j));
    chk("R4 valid", 32'(valid_o), 32'd1);
    chk(j == 0 ? "R2 W0" : (j < 16 ? "R4 W" : "R6 W"), w_o, exp_w[j]);
    chk("R3 Wp", wp_o, exp_w[j] ^ exp_w[j+4]);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(valid_o), 32'd0);
    chk("R1 round", 32'(round_o), 32'd0);
    chk("R1 w", w_o, 32'd0);
    chk("R1 wp", wp_o, 32'd0);
  endtask

  task automatic t_full_block(input logic [511:0] b, input logic stall);
    model(b);
    step_load(b, 1'b0);
    block_i = ~b; // R10: input changes after load must not matter
    for (int j = 0; j < 64; j++) begin
      chk_round(j);
      if (stall && (j % 7 == 3)) begin
        @(negedge clk_i);
        chk("R5 hold w", w_o, exp_w[j]);
        chk("R5 hold round", 32'(round_o), 32'(j));
      end
      step_next();
    end
    chk("R7 done valid", 32'(valid_o), 32'd0);
    chk("R7 done round", 32'(round_o), 32'd0);
    step_next();
    chk("R7 idle next valid", 32'(valid_o), 32'd0);
    chk("R7 idle next round", 32'(round_o), 32'd0);
  endtask

  task automatic t_restart(input logic [511:0] a, input logic [511:0] b);
    step_load(a, 1'b0);
    for (int j = 0; j < 10; j++) step_next();
    model(b);
    step_load(b, 1'b0);
    chk("R8 round", 32'(round_o), 32'd0);
    chk("R8 w", w_o, exp_w[0]);
    for (int j = 0; j < 5; j++) step_next();
    chk("R8 w5", w_o, exp_w[5]);
    chk("R8 wp5", wp_o, exp_w[5] ^ exp_w[9]);
  endtask

  task automatic t_collide(input logic [511:0] a, input logic [511:0] b);
    step_load(a, 1'b0);
    for (int j = 0; j < 3; j++) step_next();
    model(b);
    step_load(b, 1'b1);
    chk("R9 round", 32'(round_o), 32'd0);
    chk("R9 valid", 32'(valid_o), 32'd1);
    chk("R9 w", w_o, exp_w[0]);
    chk("R9 wp", wp_o, exp_w[0] ^ exp_w[4]);
    step_next();
    chk("R9 w1", w_o, exp_w[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [511:0] abc;
    logic [511:0] mix;
    abc = '0;
    abc[511:480] = 32'h6162_6380;
    abc[31:0]    = 32'h0000_0018;
    for (int k = 0; k < 16; k++)
      mix[511-32*k -: 32] = (32'(k) * 32'h9e37_79b9) ^ 32'h5a5a_0f0f ^ 32'(k << 24);

    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_full_block(abc, 1'b0);
    t_full_block(mix, 1'b1);
    t_restart(abc, mix);
    t_collide(mix, abc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule